// File: doc/BRIEF.md
# Refresh and Self-Refresh Sequencer for a Single-Data-Rate DRAM

This block is the refresh engine inside a memory controller for a single-data-rate DRAM-type device. It counts clock cycles to pace periodic auto-refresh commands. Before each auto-refresh it closes every bank with a precharge-all, but only when the bank tracker reports that a bank may be open. It then holds the command bus quiet for the refresh cycle time. While a refresh is pending or running, new host requests are held off.

On a low-power request, the block waits until no read data is still due on the data bus. It then optionally runs a burst of refreshes and places the device in self-refresh by issuing a refresh command with the clock enable low on the same edge. A wake request is honoured only while the block is in self-refresh. On wake, the block raises the clock enable and drives nothing but NOP for the setup time plus one refresh cycle. It then issues one refresh, or a whole burst in burst mode, before handing the bus back to the host.

The block has no data stream. All pins are plain level or pulse control signals, with no valid/ready handshake. `host_gnt` is a same-cycle grant of `host_req` and carries no back-pressure beyond `host_busy`.

Top module: `sdr_refresh_ctrl`

## Requirements
- R1: While reset is held and right after it, `cke` is 1, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111), and `host_busy`, `sr_active` and `pall_req` are 0.
- R2: When idle with all banks closed, refresh commands (0001 with `cke` high) are spaced exactly REF_INTERVAL cycles apart.
- R3: When a refresh falls due while `banks_open` is 1, a precharge-all (0010) is issued first, with `pall_req` high in exactly that cycle. The refresh follows exactly T_RP cycles later.
- R4: After any refresh command, the next non-NOP command comes no sooner than T_RC cycles later.
- R5: From the cycle a refresh is due until T_RC cycles after the refresh command, `host_busy` is 1 and `host_gnt` is 0.
- R6: Self-refresh entry is a refresh command with `cke` low in the same cycle. It is never issued while `rd_pending` is 1.
- R7: While `sr_active` is 1, `cke` stays 0, the command is NOP, and no refresh is issued.
- R8: `wake_req` has no effect unless `sr_active` is 1.
- R9: After a wake, `cke` rises and the next command is a refresh exactly T_CKS + T_RC cycles after the first cycle with `cke` high. Only NOPs come in between.
- R10: With `burst_mode` 0, exactly one refresh follows exit. With `burst_mode` 1, BURST_CNT refreshes spaced T_RC apart precede entry and BURST_CNT refreshes follow exit.
- R11: `host_gnt` equals `host_req` whenever the block is idle with no refresh due and no low-power request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host asks for the command bus |
| host_gnt | output | 1 | Host may use the bus this cycle |
| host_busy | output | 1 | Refresh or power sequencing owns the bus |
| lp_req | input | 1 | Request to enter self-refresh |
| wake_req | input | 1 | Request to leave self-refresh |
| rd_pending | input | 1 | Read data is still due on the data bus |
| banks_open | input | 1 | At least one bank may be open |
| burst_mode | input | 1 | Refresh in bursts around self-refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| pall_req | output | 1 | Precharge-all issued this cycle |
| sr_active | output | 1 | Device is in self-refresh |

## Verification
A stuck or mis-loaded interval counter shows up within one refresh interval as a wrong gap between two refresh commands. A wait timer that is off by one moves the refresh relative to the precharge-all or to the rise of `cke` by exactly that cycle, and the bench measures both distances. A wrong state around self-refresh shows up within a few cycles of the request: an entry while reads drain, `cke` rising during self-refresh, a refresh issued in self-refresh, or the wrong refresh count around entry and exit.

// File: rtl/sdr_ref_pkg.sv
package sdr_ref_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_REF  = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DRAIN, ST_PALL, ST_TRP, ST_REF, ST_TRC,
    ST_SRE, ST_SELF, ST_CKS, ST_XRC
  } state_e;

  typedef enum logic [1:0] {
    GOAL_REF, GOAL_ENTER, GOAL_EXIT
  } goal_e;
endpackage

// File: rtl/ref_wait_timer.sv
module ref_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= value;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R4: a nonzero load must hold off completion in the next cycle
  a_r4_wait_not_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    (load && value != '0) |=> !done);
endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL = 97
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic hold,
  output logic due
);
  localparam int W = $clog2(INTERVAL + 1);
  localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (restart)       cnt <= W'(1);
    else if (hold)          cnt <= cnt;
    else if (cnt != LAST)   cnt <= cnt + 1'b1;
  end

  assign due = (cnt == LAST);

  // R2: once due, the request persists until a refresh restarts the count
  a_r2_due_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !restart) |=> due);
endmodule

// File: rtl/sdr_refresh_ctrl.sv
module sdr_refresh_ctrl
  import sdr_ref_pkg::*;
#(
  parameter int REF_INTERVAL = 97,
  parameter int T_RC         = 5,
  parameter int T_RP         = 2,
  parameter int T_CKS        = 1,
  parameter int BURST_CNT    = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  output logic host_gnt,
  output logic host_busy,
  input  logic lp_req,
  input  logic wake_req,
  input  logic rd_pending,
  input  logic banks_open,
  input  logic burst_mode,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic cke,
  output logic pall_req,
  output logic sr_active
);
  localparam int TMAX = (T_RC > T_RP) ? ((T_RC > T_CKS) ? T_RC : T_CKS)
                                      : ((T_RP > T_CKS) ? T_RP : T_CKS);
  localparam int TW = $clog2(TMAX + 1);
  localparam int BW = $clog2(BURST_CNT + 1);
  localparam int SW = $clog2(T_CKS + T_RC + TMAX + 1);

  state_e          state, state_n;
  goal_e           goal, goal_n;
  logic [BW-1:0]   burst_left, left_n, burst_init;
  logic            t_load, t_done, due, iv_restart, iv_hold;
  logic [TW-1:0]   t_val;
  cmd_e            cmd;

  ref_wait_timer #(.W(TW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(t_load), .value(t_val), .done(t_done)
  );

  ref_interval_timer #(.INTERVAL(REF_INTERVAL)) u_interval (
    .clk(clk), .rst_n(rst_n), .restart(iv_restart), .hold(iv_hold), .due(due)
  );

  assign burst_init = burst_mode ? BW'(BURST_CNT) : '0;
  assign iv_hold    = (state == ST_SRE) || (state == ST_SELF) ||
                      (state == ST_CKS) || (state == ST_XRC);

  always_comb begin
    state_n    = state;
    goal_n     = goal;
    left_n     = burst_left;
    t_load     = 1'b0;
    t_val      = '0;
    iv_restart = 1'b0;
    case (state)
      ST_IDLE: begin
        if (due) begin
          goal_n  = GOAL_REF;
          state_n = banks_open ? ST_PALL : ST_REF;
        end else if (lp_req) begin
          goal_n  = GOAL_ENTER;
          left_n  = burst_init;
          state_n = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!lp_req) begin
          state_n = ST_IDLE;
        end else if (!rd_pending) begin
          if (banks_open)             state_n = ST_PALL;
          else if (burst_left != '0)  state_n = ST_REF;
          else                        state_n = ST_SRE;
        end else if (due) begin
          goal_n  = GOAL_REF;
          left_n  = '0;
          state_n = banks_open ? ST_PALL : ST_REF;
        end
      end
      ST_PALL: begin
        t_load  = 1'b1;
        t_val   = TW'(T_RP - 2);
        state_n = ST_TRP;
      end
      ST_TRP: begin
        if (t_done)
          state_n = (goal == GOAL_ENTER && burst_left == '0) ? ST_SRE : ST_REF;
      end
      ST_REF: begin
        iv_restart = 1'b1;
        t_load     = 1'b1;
        t_val      = TW'(T_RC - 2);
        if (burst_left != '0) left_n = burst_left - 1'b1;
        state_n    = ST_TRC;
      end
      ST_TRC: begin
        if (t_done) begin
          if (burst_left != '0)       state_n = ST_REF;
          else if (goal == GOAL_ENTER) state_n = ST_SRE;
          else                        state_n = ST_IDLE;
        end
      end
      ST_SRE:  state_n = ST_SELF;
      ST_SELF: begin
        if (wake_req) begin
          t_load  = 1'b1;
          t_val   = TW'(T_CKS - 1);
          state_n = ST_CKS;
        end
      end
      ST_CKS: begin
        if (t_done) begin
          t_load  = 1'b1;
          t_val   = TW'(T_RC - 1);
          state_n = ST_XRC;
        end
      end
      ST_XRC: begin
        if (t_done) begin
          goal_n  = GOAL_EXIT;
          left_n  = burst_mode ? BW'(BURST_CNT) : BW'(1);
          state_n = ST_REF;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      goal       <= GOAL_REF;
      burst_left <= '0;
    end else begin
      state      <= state_n;
      goal       <= goal_n;
      burst_left <= left_n;
    end
  end

  always_comb begin
    cmd = CMD_NOP;
    cke = 1'b1;
    case (state)
      ST_PALL: cmd = CMD_PALL;
      ST_REF:  cmd = CMD_REF;
      ST_SRE:  begin cmd = CMD_REF; cke = 1'b0; end
      ST_SELF: cke = 1'b0;
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign pall_req  = (state == ST_PALL);
  assign sr_active = (state == ST_SELF);
  assign host_busy = (state != ST_IDLE) || due || lp_req;
  assign host_gnt  = host_req && !host_busy;

  // ---------------- assertions and their spacing counters ----------------
  logic          bus_ref, bus_pall, bus_cmd;
  logic [SW-1:0] since_ref, since_pall, since_cke;

  assign bus_ref  = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);
  assign bus_pall = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
  assign bus_cmd  = ({cs_n, ras_n, cas_n, we_n} != 4'b0111);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ref  <= '1;
      since_pall <= '1;
      since_cke  <= '1;
    end else begin
      if (bus_ref)               since_ref <= SW'(1);
      else if (since_ref != '1)  since_ref <= since_ref + 1'b1;
      if (bus_pall)              since_pall <= SW'(1);
      else if (since_pall != '1) since_pall <= since_pall + 1'b1;
      if (!cke)                  since_cke <= '0;
      else if (since_cke != '1)  since_cke <= since_cke + 1'b1;
    end
  end

  a_r3_pall_to_ref: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ref |-> since_pall >= SW'(T_RP));

  a_r4_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd |-> since_ref >= SW'(T_RC));

  a_r5_no_grant_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> (!bus_cmd && cke && !pall_req));

  a_r6_entry_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (bus_ref && !rd_pending));

  a_r7_quiet_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> (!cke && !bus_cmd));

  a_r9_exit_window: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd && cke) |-> since_cke >= SW'(T_CKS + T_RC));
endmodule

// File: tb/test_sdr_refresh_ctrl.sv
module test_sdr_refresh_ctrl;
  localparam int IV  = 40;
  localparam int RC  = 5;
  localparam int RP  = 3;
  localparam int CKS = 2;
  localparam int BC  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 0, lp_req = 0, wake_req = 0, rd_pending = 0;
  logic banks_open = 0, burst_mode = 0;
  logic host_gnt, host_busy, cs_n, ras_n, cas_n, we_n, cke, pall_req, sr_active;

  sdr_refresh_ctrl #(.REF_INTERVAL(IV), .T_RC(RC), .T_RP(RP), .T_CKS(CKS),
                     .BURST_CNT(BC)) i_sdr_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_gnt(host_gnt),
    .host_busy(host_busy), .lp_req(lp_req), .wake_req(wake_req),
    .rd_pending(rd_pending), .banks_open(banks_open), .burst_mode(burst_mode),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
    .pall_req(pall_req), .sr_active(sr_active)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int ref_cnt = 0, sre_cnt = 0, pall_cnt = 0;
  int last_ref = -1000, prev_ref = -1000, last_any_ref = -1000;
  int last_pall = -1000, cke_rise = -1000, gap_viol = 0, pr_mis = 0;
  logic cke_q = 1'b1;

  function automatic logic [3:0] bus();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus() != 4'b0111 && (cyc - last_any_ref) < RC) gap_viol++;
      if (bus() == 4'b0001) begin
        last_any_ref = cyc;
        if (cke) begin ref_cnt++; prev_ref = last_ref; last_ref = cyc; end
        else sre_cnt++;
      end
      if (bus() == 4'b0010) begin pall_cnt++; last_pall = cyc; end
      if ((bus() == 4'b0010) != pall_req) pr_mis++;
      if (cke && !cke_q) cke_rise = cyc;
      cke_q = cke;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ref_then_idle();
    int r = ref_cnt;
    while (ref_cnt == r) tick();
    repeat (RC) tick();
  endtask

  task automatic t_reset();
    tick();
    chk(cke && bus() == 4'b0111 && !host_busy && !sr_active && !pall_req,
        "R1 reset outputs", {cke, bus(), host_busy, sr_active, pall_req}, 8'b1_0111_000);
    rst_n = 1'b1;
    tick();
    chk(cke && bus() == 4'b0111 && !sr_active && !pall_req,
        "R1 after reset", {cke, bus()}, 5'b1_0111);
  endtask

  task automatic t_distributed();
    int n = ref_cnt;
    while (ref_cnt < n + 2) tick();
    chk(last_ref - prev_ref == IV, "R2 refresh spacing", last_ref - prev_ref, IV);
  endtask

  task automatic t_precharge();
    int p, r;
    banks_open = 1'b1;
    p = pall_cnt;
    while (pall_cnt == p) tick();
    r = ref_cnt;
    while (ref_cnt == r) tick();
    banks_open = 1'b0;
    chk(last_ref - last_pall == RP, "R3 precharge to refresh", last_ref - last_pall, RP);
    chk(pr_mis == 0, "R3 pall_req matches command", pr_mis, 0);
  endtask

  task automatic t_host();
    int r, bad = 0;
    wait_ref_then_idle();
    host_req = 1'b1;
    tick();
    chk(host_gnt == 1'b1, "R11 grant when idle", host_gnt, 1);
    r = ref_cnt;
    while (ref_cnt == r) begin
      if (host_busy && host_gnt) bad++;
      tick();
    end
    chk(host_busy && !host_gnt, "R5 busy at refresh", {host_busy, host_gnt}, 2'b10);
    for (int k = 1; k < RC; k++) begin
      tick();
      if (!host_busy || host_gnt) bad++;
    end
    chk(bad == 0, "R5 busy through tRC", bad, 0);
    tick();
    chk(host_gnt && !host_busy, "R11 grant after tRC", {host_gnt, host_busy}, 2'b10);
    host_req = 1'b0;
  endtask

  task automatic t_wake_ignored();
    int bad = 0;
    wait_ref_then_idle();
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    repeat (4) begin
      tick();
      if (!cke || sr_active || bus() != 4'b0111) bad++;
    end
    chk(bad == 0, "R8 wake outside self-refresh", bad, 0);
  endtask

  task automatic t_selfref_single();
    int s, r, bad = 0;
    wait_ref_then_idle();
    s = sre_cnt;
    rd_pending = 1'b1;
    lp_req = 1'b1;
    repeat (8) begin
      tick();
      if (!cke || sr_active) bad++;
    end
    chk(bad == 0 && sre_cnt == s, "R6 entry waits for reads", sre_cnt - s, 0);
    rd_pending = 1'b0;
    while (!sr_active) tick();
    chk(sre_cnt == s + 1, "R6 entry is refresh with cke low", sre_cnt - s, 1);
    lp_req = 1'b0;
    r = ref_cnt;
    bad = 0;
    repeat (IV + 20) begin
      tick();
      if (cke || !sr_active || bus() != 4'b0111) bad++;
    end
    chk(bad == 0, "R7 held in self-refresh", bad, 0);
    chk(ref_cnt == r, "R7 no refresh in self-refresh", ref_cnt - r, 0);
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    while (ref_cnt == r) tick();
    chk(last_ref - cke_rise == CKS + RC, "R9 exit refresh timing",
        last_ref - cke_rise, CKS + RC);
    repeat (RC + 4) tick();
    chk(ref_cnt == r + 1, "R10 single refresh after exit", ref_cnt - r, 1);
  endtask

  task automatic t_selfref_burst();
    int r;
    burst_mode = 1'b1;
    wait_ref_then_idle();
    r = ref_cnt;
    lp_req = 1'b1;
    while (!sr_active) tick();
    chk(ref_cnt - r == BC, "R10 burst before entry", ref_cnt - r, BC);
    chk(last_ref - prev_ref == RC, "R10 burst spacing", last_ref - prev_ref, RC);
    lp_req = 1'b0;
    repeat (5) tick();
    r = ref_cnt;
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    repeat (CKS + RC + BC * RC + 8) tick();
    chk(ref_cnt - r == BC, "R10 burst after exit", ref_cnt - r, BC);
    burst_mode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    t_reset();
    t_distributed();
    t_precharge();
    t_host();
    t_wake_ignored();
    t_selfref_single();
    t_selfref_burst();
    t_distributed();
    chk(gap_viol == 0, "R4 command after refresh too early", gap_viol, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule